// File: doc/BRIEF.md
# Step-Pulse Page Program Sequencer with Suspend and Resume

This block runs one page-program operation as a series of step-pulse iterations. Each iteration applies a program pulse and then a verify read. Both phases finish with a short interval in which the operating voltages are discharged. Before the first pulse, the sequencer copies the page buffer into a shadow buffer. A higher-priority read can then preempt the write and overwrite the page buffer. On resume, the sequencer copies the data back before any phase runs.

A controller issues single-cycle start, suspend and resume commands. The `cancel_mode` input chooses how a suspend is honoured. With `cancel_mode` low, the current phase always runs to its end. With `cancel_mode` high, a phase still in its active portion is abandoned at once. The sequencer saves the iteration number, the point at which to resume, and whether a pulse was cut short. This lets a cut pulse be checked by a verify before any new pulse is applied. All durations are parameters counted in clock cycles. Iteration-limit and verify-length presets cover single-level and multi-level cells: 5 or 15 iterations, with verify times of 8 µs or 24 µs. The analog side sees only the phase indicator outputs and returns `verify_pass`.

Top module: `ispp_prog_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, all outputs are 0 and `iter_idx` is 0 until a start is accepted.
- R2: A `cmd_start` accepted while not busy raises `busy` and `shadow_save` on the next cycle. `shadow_save` stays high for COPY_CYC cycles, and the first program pulse follows directly after it.
- R3: An iteration consists of `prog_pulse` for PROG_CYC cycles, `vreset_on` for VRST_CYC cycles, `verify_on` for VER_CYC cycles, and `vreset_on` for VRST_CYC cycles. `verify_pass` is sampled on the last cycle in which `verify_on` is high.
- R4: A passing verify ends the operation on the cycle after its voltage-reset interval. At that point `done`=1, `fail`=0 and `busy`=0, and `iter_idx` holds the iteration number, counting from 1.
- R5: If the verify of iteration MAX_ITER fails, `done` and `fail` rise together and `iter_idx` equals MAX_ITER.
- R6: With `cancel_mode`=0, a suspend is held until the current phase, including its voltage reset, has finished. `suspended` rises on the next cycle.
- R7: With `cancel_mode`=1, a suspend during the active part of a program or verify phase ends that phase. `vreset_on` is high for VRST_CYC cycles starting the next cycle, and `suspended` follows.
- R8: With `cancel_mode`=1, a suspend that arrives during a voltage-reset interval takes effect when that interval ends, with the same timing as R6.
- R9: A resume while suspended drives `shadow_restore` for COPY_CYC cycles starting the next cycle. If the last completed phase was a program pulse, a verify then runs. If it was a failing verify, the next iteration's program pulse runs.
- R10: After a cancelled verify, the verify is rerun. After a cancelled pulse, a verify runs first. If that verify passes, the operation ends with no further pulse. If it fails, the pulse is repeated without advancing `iter_idx`.
- R11: `cmd_resume` has no effect unless the sequencer is suspended. `cmd_start` has no effect while busy. `cmd_suspend` has no effect while idle or done.
- R12: If a suspend falls on the last voltage-reset cycle of a verify that ends the operation, the operation completes and `suspended` never rises.
- R13: At most one of `prog_pulse`, `verify_on`, `vreset_on`, `shadow_save`, `shadow_restore`, `suspended` and `done` is high in any cycle. `busy` stays high while suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_start | input | 1 | Begin a program operation (single-cycle pulse) |
| cmd_suspend | input | 1 | Request suspension (single-cycle pulse) |
| cmd_resume | input | 1 | Resume a suspended operation (single-cycle pulse) |
| cancel_mode | input | 1 | 0: suspend at phase end; 1: cancel the active phase |
| verify_pass | input | 1 | Verify result from the array, 1 = all cells reached target |
| busy | output | 1 | Operation in progress, including while suspended |
| suspended | output | 1 | Operation suspended, the array is free |
| done | output | 1 | Operation finished (held until the next start) |
| fail | output | 1 | With done: verify never passed |
| prog_pulse | output | 1 | Program pulse being applied |
| verify_on | output | 1 | Verify read in progress |
| vreset_on | output | 1 | Operating-voltage reset in progress |
| shadow_save | output | 1 | Page buffer being copied to the shadow buffer |
| shadow_restore | output | 1 | Shadow buffer being copied back to the page buffer |
| iter_idx | output | IW | Current iteration number, from 1 |

## Verification
The main collision is between a suspend and the end of the operation. The bench times a suspend pulse so that it is sampled on the final voltage-reset cycle of a passing verify, in both modes. It passes only if `done` rises on the normal completion cycle and `suspended` is never seen. A second collision is a suspend that lands inside a voltage-reset interval while cancel mode is on. That suspend must wait for the interval to end rather than cut it short. The bench judges it by the cycle in which `suspended` rises and by the later completion time.

// File: rtl/ispp_seq_pkg.sv
`timescale 1ns/1ps
// Shared types and presets for the step-pulse program sequencer.
// Assumes a 200 MHz clock for the preset cycle counts.
package ispp_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SAVE,
        ST_PROG,
        ST_PROG_VR,
        ST_VER,
        ST_VER_VR,
        ST_CANCEL_VR,
        ST_HOLD,
        ST_RESTORE,
        ST_DONE
    } seq_state_t;

    typedef enum logic {
        RP_PULSE  = 1'b0,
        RP_VERIFY = 1'b1
    } resume_pt_t;

    localparam int SLC_ITERS      = 5;
    localparam int MLC_ITERS      = 15;
    localparam int PROG_CYC_200   = 4000;  // 20 us
    localparam int SLC_VER_CYC    = 1600;  // 8 us
    localparam int MLC_VER_CYC    = 4800;  // 24 us
    localparam int VRST_CYC_200   = 800;   // 4 us
    localparam int COPY_CYC_200   = 600;   // 3 us

    // Iteration limit for the chosen cell type.
    function automatic int preset_iters(input bit mlc);
        return mlc ? MLC_ITERS : SLC_ITERS;
    endfunction

    // Verify duration for the chosen cell type.
    function automatic int preset_ver_cyc(input bit mlc);
        return mlc ? MLC_VER_CYC : SLC_VER_CYC;
    endfunction

    // Largest of four values, used to size the phase timer.
    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/ispp_phase_timer.sv
`timescale 1ns/1ps
// Down-counting phase timer shared by every timed state.
// Assumes load values of at least 1; expired is high on the last
// cycle of the loaded duration.
module ispp_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_len,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    // Load the new duration minus one, or count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_len - TW'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ispp_susp_latch.sv
`timescale 1ns/1ps
// Holds a suspend request until the sequencer acts on it.
// A request in the same cycle is visible at once through pend.
// Assumes clear wins over a same-cycle request.
module ispp_susp_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic accept,
    input  logic clear,
    output logic pend
);

    logic pend_q;

    assign pend = pend_q | (req & accept);

    // Keep the request until the sequencer parks or finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (clear) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend;
        end
    end

endmodule

// File: rtl/ispp_resume_ctx.sv
`timescale 1ns/1ps
// Context saved across a suspension: iteration number, resume point,
// cut-pulse recheck flag and the last sampled verify result.
// Assumes init, iter_inc and the recheck strobes are never needed
// in conflicting combinations (init has priority).
module ispp_resume_ctx
    import ispp_seq_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          iter_inc,
    input  logic          rp_we,
    input  resume_pt_t    rp_in,
    input  logic          rck_set,
    input  logic          rck_clr,
    input  logic          vp_we,
    input  logic          vp_in,
    output logic [IW-1:0] iter,
    output resume_pt_t    rp,
    output logic          recheck,
    output logic          vpass
);

    // Iteration counter, starts at 1 for each new operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iter <= '0;
        end else if (init) begin
            iter <= IW'(1);
        end else if (iter_inc) begin
            iter <= iter + IW'(1);
        end
    end

    // Point at which a resumed operation continues.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp <= RP_PULSE;
        end else if (init) begin
            rp <= RP_PULSE;
        end else if (rp_we) begin
            rp <= rp_in;
        end
    end

    // Marks that the next verify follows a cut pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recheck <= 1'b0;
        end else if (init || rck_clr) begin
            recheck <= 1'b0;
        end else if (rck_set) begin
            recheck <= 1'b1;
        end
    end

    // Verify result captured on the last active verify cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpass <= 1'b0;
        end else if (init) begin
            vpass <= 1'b0;
        end else if (vp_we) begin
            vpass <= vp_in;
        end
    end

endmodule

// File: rtl/ispp_prog_seq.sv
`timescale 1ns/1ps
// Step-pulse page program sequencer with suspend and resume.
// Runs up to MAX_ITER pulse/verify iterations. Each phase ends with a
// voltage reset. The sequencer saves the page buffer into a shadow
// copy at start and restores it on resume. cancel_mode picks between
// suspending at phase ends and cancelling the active phase.
// Assumes all durations are at least 1 cycle and commands are pulses.
module ispp_prog_seq
    import ispp_seq_pkg::*;
#(
    parameter bit MLC_PRESET = 1'b0,
    parameter int MAX_ITER   = preset_iters(MLC_PRESET),
    parameter int PROG_CYC   = PROG_CYC_200,
    parameter int VER_CYC    = preset_ver_cyc(MLC_PRESET),
    parameter int VRST_CYC   = VRST_CYC_200,
    parameter int COPY_CYC   = COPY_CYC_200,
    localparam int IW        = $clog2(MAX_ITER + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic          cmd_suspend,
    input  logic          cmd_resume,
    input  logic          cancel_mode,
    input  logic          verify_pass,
    output logic          busy,
    output logic          suspended,
    output logic          done,
    output logic          fail,
    output logic          prog_pulse,
    output logic          verify_on,
    output logic          vreset_on,
    output logic          shadow_save,
    output logic          shadow_restore,
    output logic [IW-1:0] iter_idx
);

    localparam int LEN_MAX = max4(PROG_CYC, VER_CYC, VRST_CYC, COPY_CYC);
    localparam int TW      = $clog2(LEN_MAX + 1);

    seq_state_t    st_q, st_nxt;
    logic          t_exp, t_load;
    logic [TW-1:0] t_len;
    logic          pend, running, pend_clear, cut_now;
    logic          init, iter_inc, rp_we, rck_set, rck_clr, vp_we, fin_fail;
    resume_pt_t    rp_in, rp;
    logic          recheck, vpass, last_iter, fail_q;
    logic [IW-1:0] iter;

    assign running    = (st_q != ST_IDLE) && (st_q != ST_DONE) && (st_q != ST_HOLD);
    assign cut_now    = pend && cancel_mode;
    assign last_iter  = (iter == IW'(MAX_ITER));
    assign init       = ((st_q == ST_IDLE) || (st_q == ST_DONE)) && cmd_start;
    assign vp_we      = (st_q == ST_VER) && t_exp && !cut_now;
    assign pend_clear = (st_nxt == ST_HOLD) || (st_nxt == ST_DONE);

    ispp_susp_latch u_susp (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (cmd_suspend),
        .accept (running),
        .clear  (pend_clear),
        .pend   (pend)
    );

    ispp_resume_ctx #(.IW(IW)) u_ctx (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (init),
        .iter_inc (iter_inc),
        .rp_we    (rp_we),
        .rp_in    (rp_in),
        .rck_set  (rck_set),
        .rck_clr  (rck_clr),
        .vp_we    (vp_we),
        .vp_in    (verify_pass),
        .iter     (iter),
        .rp       (rp),
        .recheck  (recheck),
        .vpass    (vpass)
    );

    ispp_phase_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_len (t_len),
        .expired  (t_exp)
    );

    // Duration of the state about to be entered.
    always_comb begin
        case (st_nxt)
            ST_SAVE, ST_RESTORE:                   t_len = TW'(COPY_CYC);
            ST_PROG:                               t_len = TW'(PROG_CYC);
            ST_VER:                                t_len = TW'(VER_CYC);
            ST_PROG_VR, ST_VER_VR, ST_CANCEL_VR:   t_len = TW'(VRST_CYC);
            default:                               t_len = TW'(1);
        endcase
    end

    assign t_load = (st_nxt != st_q);

    // Next-state and context-update decisions.
    always_comb begin
        st_nxt   = st_q;
        iter_inc = 1'b0;
        rp_we    = 1'b0;
        rp_in    = RP_PULSE;
        rck_set  = 1'b0;
        rck_clr  = 1'b0;
        fin_fail = 1'b0;
        case (st_q)
            ST_IDLE, ST_DONE: begin
                if (cmd_start) st_nxt = ST_SAVE;
            end
            ST_SAVE: begin
                if (t_exp) st_nxt = ST_PROG;
            end
            ST_PROG: begin
                if (cut_now) begin
                    st_nxt  = ST_CANCEL_VR;
                    rp_we   = 1'b1;
                    rp_in   = RP_VERIFY;
                    rck_set = 1'b1;
                end else if (t_exp) begin
                    st_nxt = ST_PROG_VR;
                end
            end
            ST_PROG_VR: begin
                if (t_exp) begin
                    if (pend) begin
                        st_nxt = ST_HOLD;
                        rp_we  = 1'b1;
                        rp_in  = RP_VERIFY;
                    end else begin
                        st_nxt = ST_VER;
                    end
                end
            end
            ST_VER: begin
                if (cut_now) begin
                    st_nxt = ST_CANCEL_VR;
                    rp_we  = 1'b1;
                    rp_in  = RP_VERIFY;
                end else if (t_exp) begin
                    st_nxt = ST_VER_VR;
                end
            end
            ST_VER_VR: begin
                if (t_exp) begin
                    if (vpass) begin
                        st_nxt = ST_DONE;
                    end else if (!recheck && last_iter) begin
                        st_nxt   = ST_DONE;
                        fin_fail = 1'b1;
                    end else begin
                        iter_inc = !recheck;
                        rck_clr  = 1'b1;
                        if (pend) begin
                            st_nxt = ST_HOLD;
                            rp_we  = 1'b1;
                            rp_in  = RP_PULSE;
                        end else begin
                            st_nxt = ST_PROG;
                        end
                    end
                end
            end
            ST_CANCEL_VR: begin
                if (t_exp) st_nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (cmd_resume) st_nxt = ST_RESTORE;
            end
            ST_RESTORE: begin
                if (t_exp) st_nxt = (rp == RP_PULSE) ? ST_PROG : ST_VER;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Failure flag, cleared by each new start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
        end else if (init) begin
            fail_q <= 1'b0;
        end else if (fin_fail) begin
            fail_q <= 1'b1;
        end
    end

    assign busy           = (st_q != ST_IDLE) && (st_q != ST_DONE);
    assign suspended      = (st_q == ST_HOLD);
    assign done           = (st_q == ST_DONE);
    assign fail           = fail_q && (st_q == ST_DONE);
    assign prog_pulse     = (st_q == ST_PROG);
    assign verify_on      = (st_q == ST_VER);
    assign vreset_on      = (st_q == ST_PROG_VR) || (st_q == ST_VER_VR) || (st_q == ST_CANCEL_VR);
    assign shadow_save    = (st_q == ST_SAVE);
    assign shadow_restore = (st_q == ST_RESTORE);
    assign iter_idx       = iter;

endmodule

// File: rtl/ispp_prog_seq_chk.sv
`timescale 1ns/1ps
// Port-level property checker for the program sequencer, bound to
// every instance. Assumes synchronous active-low reset.
module ispp_prog_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_suspend,
    input logic cancel_mode,
    input logic busy,
    input logic suspended,
    input logic done,
    input logic fail,
    input logic prog_pulse,
    input logic verify_on,
    input logic vreset_on,
    input logic shadow_save,
    input logic shadow_restore
);

    assert_start_saves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> shadow_save);

    assert_pulse_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_pulse) |-> ($past(shadow_save) || $past(vreset_on) || $past(shadow_restore)));

    assert_verify_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(verify_on) |-> ($past(vreset_on) || $past(shadow_restore)));

    assert_fail_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    assert_park_after_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspended) |-> $past(vreset_on));

    assert_cancel_quick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_mode && cmd_suspend && (prog_pulse || verify_on)) |=> vreset_on);

    assert_restore_from_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shadow_restore) |-> $past(suspended));

    assert_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_pulse, verify_on, vreset_on, shadow_save, shadow_restore, suspended, done}));

    assert_busy_when_parked_R13: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> busy);

endmodule

bind ispp_prog_seq ispp_prog_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_suspend    (cmd_suspend),
    .cancel_mode    (cancel_mode),
    .busy           (busy),
    .suspended      (suspended),
    .done           (done),
    .fail           (fail),
    .prog_pulse     (prog_pulse),
    .verify_on      (verify_on),
    .vreset_on      (vreset_on),
    .shadow_save    (shadow_save),
    .shadow_restore (shadow_restore)
);

// File: tb/sim_ispp_prog_seq.sv
`timescale 1ns/1ps
// Bench for the program sequencer: a vector table of whole operations,
// then directed reset and ignored-command tests.
module sim_ispp_prog_seq;

    localparam int NI = 3;
    localparam int PC = 6;
    localparam int VC = 4;
    localparam int RC = 2;
    localparam int CC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0, cmd_suspend = 1'b0, cmd_resume = 1'b0, cancel_mode = 1'b0;
    logic verify_pass;
    logic busy, suspended, done, fail, prog_pulse, verify_on, vreset_on;
    logic shadow_save, shadow_restore;
    logic [1:0] iter_idx;

    always #2.5 clk = ~clk;

    ispp_prog_seq #(
        .MAX_ITER (NI),
        .PROG_CYC (PC),
        .VER_CYC  (VC),
        .VRST_CYC (RC),
        .COPY_CYC (CC)
    ) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_start      (cmd_start),
        .cmd_suspend    (cmd_suspend),
        .cmd_resume     (cmd_resume),
        .cancel_mode    (cancel_mode),
        .verify_pass    (verify_pass),
        .busy           (busy),
        .suspended      (suspended),
        .done           (done),
        .fail           (fail),
        .prog_pulse     (prog_pulse),
        .verify_on      (verify_on),
        .vreset_on      (vreset_on),
        .shadow_save    (shadow_save),
        .shadow_restore (shadow_restore),
        .iter_idx       (iter_idx)
    );

    int checks = 0;
    int failures = 0;
    int gcyc = 0;

    // Verify-phase counter driving the array's pass answer.
    int vcount = 0;
    int vbase = 0;
    int pass_at = 0;
    logic vprev = 1'b0;
    always @(negedge clk) begin
        if (verify_on && !vprev) vcount <= vcount + 1;
        vprev <= verify_on;
    end
    assign verify_pass = (pass_at != 0) && ((vcount - vbase) >= pass_at);

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        gcyc <= gcyc + 1;
        if (gcyc > 20000) begin
            failures = failures + 1;
            $display("FAIL watchdog act=%0d exp=<20000", gcyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    typedef struct packed {
        int pa; int cm; int s; int d; int stray;
        int e_susp; int e_rest; int e_done; int e_fail; int e_iter; int req;
    } vec_t;

    // pa: verify number that first passes (0 = never); s: cycle at which
    // suspend is sampled; d: idle cycles before resume; stray: cycle of an
    // extra start+resume pulse. Expected cycles count edges after start.
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1, 0,  0, 0, 0,  0,  0, 17, 0, 1,  4},   // R4 pass first verify
        '{2, 0,  0, 0, 0,  0,  0, 31, 0, 2,  4},   // R4 pass second verify
        '{0, 0,  0, 0, 0,  0,  0, 45, 1, 3,  5},   // R5 never passes
        '{1, 0,  5, 2, 0, 11, 14, 22, 0, 1,  6},   // R6 boundary, pulse held
        '{2, 0, 13, 2, 0, 17, 20, 36, 0, 2,  9},   // R9 resume into next pulse
        '{1, 1,  5, 2, 0,  7, 10, 18, 0, 1,  7},   // R7 cut pulse, recheck passes
        '{2, 1,  5, 2, 0,  7, 10, 32, 0, 1, 10},   // R10 recheck fails, pulse redone
        '{1, 1, 10, 2, 0, 11, 14, 22, 0, 1,  8},   // R8 suspend inside reset
        '{2, 1, 13, 2, 0, 15, 18, 26, 0, 1, 10},   // R10 cut verify rerun
        '{1, 0, 17, 0, 0,  0,  0, 17, 0, 1, 12},   // R12 completion wins
        '{1, 1, 17, 0, 0,  0,  0, 17, 0, 1, 12},   // R12 completion wins, cancel
        '{1, 0,  0, 0, 6,  0,  0, 17, 0, 1, 11}    // R11 stray start/resume
    };

    int t_susp, t_rest, t_done, n_save, n_prog, n_ver, n_vrst, f_prog, f_ver;
    bit bad_excl;

    task automatic run_op(input int pa, input int cm, input int s, input int d, input int stray);
        @(negedge clk);
        pass_at = pa;
        vbase = vcount;
        cancel_mode = cm[0];
        cmd_start = 1'b1;
        t_susp = 0; t_rest = 0; t_done = 0;
        n_save = 0; n_prog = 0; n_ver = 0; n_vrst = 0; f_prog = 0; f_ver = 0;
        bad_excl = 1'b0;
        for (int cyc = 1; cyc < 400; cyc++) begin
            @(negedge clk);
            if (suspended && t_susp == 0) t_susp = cyc;
            if (shadow_restore && t_rest == 0) t_rest = cyc;
            if (shadow_save) n_save++;
            if (prog_pulse) begin n_prog++; if (f_prog == 0) f_prog = cyc; end
            if (verify_on) begin n_ver++; if (f_ver == 0) f_ver = cyc; end
            if (vreset_on) n_vrst++;
            if ($countones({prog_pulse, verify_on, vreset_on, shadow_save, shadow_restore, suspended, done}) > 1
                || (suspended && !busy) || (done && busy)) bad_excl = 1'b1;
            cmd_start   = (stray != 0) && (cyc == stray - 1);
            cmd_resume  = cmd_start || ((t_susp != 0) && (cyc == t_susp + d));
            cmd_suspend = (s != 0) && (cyc == s - 1);
            if (done) begin
                t_done = cyc;
                break;
            end
        end
        cmd_start = 1'b0;
        cmd_suspend = 1'b0;
        cmd_resume = 1'b0;
    endtask

    task automatic chk_all_low(input string what);
        chk({busy, suspended, done, fail, prog_pulse, verify_on, vreset_on,
             shadow_save, shadow_restore} == 9'b0 && iter_idx == 2'd0,
            "R1", what, int'({busy, suspended, done, fail}), 0);
    endtask

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        chk_all_low("outputs during reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_all_low("outputs after reset release");

        // R11: suspend and resume while idle have no effect
        cmd_suspend = 1'b1; cmd_resume = 1'b1;
        @(negedge clk);
        cmd_suspend = 1'b0; cmd_resume = 1'b0;
        repeat (3) @(negedge clk);
        chk(!suspended && !shadow_restore && !busy, "R11", "idle suspend/resume", int'(suspended), 0);

        // Table of whole operations
        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].pa, VECS[i].cm, VECS[i].s, VECS[i].d, VECS[i].stray);
            chk(t_susp == VECS[i].e_susp, $sformatf("R%0d", VECS[i].req), $sformatf("vec%0d suspend cycle", i), t_susp, VECS[i].e_susp);
            chk(t_rest == VECS[i].e_rest, $sformatf("R%0d", VECS[i].req), $sformatf("vec%0d restore cycle", i), t_rest, VECS[i].e_rest);
            chk(t_done == VECS[i].e_done, $sformatf("R%0d", VECS[i].req), $sformatf("vec%0d done cycle", i), t_done, VECS[i].e_done);
            chk(int'(fail) == VECS[i].e_fail, $sformatf("R%0d", VECS[i].req), $sformatf("vec%0d fail", i), int'(fail), VECS[i].e_fail);
            chk(int'(iter_idx) == VECS[i].e_iter, $sformatf("R%0d", VECS[i].req), $sformatf("vec%0d iteration", i), int'(iter_idx), VECS[i].e_iter);
            chk(!bad_excl, "R13", $sformatf("vec%0d status exclusivity", i), int'(bad_excl), 0);
            if (i == 0) begin
                // R2: shadow save length and first pulse timing
                chk(n_save == CC, "R2", "shadow_save cycles", n_save, CC);
                chk(f_prog == CC + 1, "R2", "first pulse cycle", f_prog, CC + 1);
                // R3: phase durations of one iteration
                chk(n_prog == PC, "R3", "pulse cycles", n_prog, PC);
                chk(f_ver == CC + PC + RC + 1, "R3", "first verify cycle", f_ver, CC + PC + RC + 1);
                chk(n_ver == VC, "R3", "verify cycles", n_ver, VC);
                chk(n_vrst == 2 * RC, "R3", "voltage reset cycles", n_vrst, 2 * RC);
                chk(!busy, "R4", "busy low at done", int'(busy), 0);
            end
        end

        // R11: resume while done leaves the finished state alone
        cmd_resume = 1'b1;
        @(negedge clk);
        cmd_resume = 1'b0;
        repeat (2) @(negedge clk);
        chk(done && !shadow_restore && !busy, "R11", "resume while done", int'(done), 1);

        // R1: reset in the middle of an operation
        run_op(1, 0, 0, 0, 0);
        @(negedge clk);
        cmd_start = 1'b1;
        repeat (5) begin
            @(negedge clk);
            cmd_start = 1'b0;
        end
        rst_n = 1'b0;
        @(negedge clk);
        chk_all_low("outputs after mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule